// File: doc/BRIEF.md
# LIN Controller Register File with Debug-Halt Access Rules

This block is the byte-wide register interface of a LIN/UART serial controller. A host reads and writes seven registers over a simple bus: control, status, error, bit timing, identifier, buffer index and data. The framing engine, the baud generator and the line transceiver sit outside the block. They report to it through event pulses and live status inputs, and they take configuration, the protected identifier and a freeze signal back from it.

The block runs under two sets of access rules. In normal operation, hardware events set the status and error flags and software clears them by writing one. The data register walks an eight-byte buffer and can advance its index on every access. When the debug-halt input is high, the block freezes the engine one cycle later. Flags then take whatever value is written. A write to the error summary bit fills or empties the whole error register. The buffer index stays where software put it. In UART mode the data register is a single transmit byte on writes and the last received byte on reads, and the index register has no effect.

Register map (3-bit address): 0 control, 1 status, 2 error, 3 bit timing, 4 identifier, 5 buffer index, 6 data.

Top module: `lin_regfile`

## Requirements
- R1: Writing a byte with bit 7 set to the control register (address 0) drives `soft_reset` high for exactly the next cycle. Bit 7 always reads back 0. This holds whether or not the block is halted.
- R2: Control bits 6:0 are read/write in both modes and appear on `ctrl_cfg`. Bit 6 selects UART mode, bit 5 enables index auto-increment, bit 4 is the disable-resynchronisation bit, and bits 3:0 are general configuration. The reset value is 0.
- R3: Status bits 7:5 show `fsm_state` and bit 4 shows `fsm_busy` at all times. Bus writes never change these bits.
- R4: In normal mode, status bit 0 (receive complete) and bit 1 (transmit complete) are set by `ev_rx_ok` and `ev_tx_ok`. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: In normal mode, each `ev_err` bit sets the matching bit of the error register (address 2). Writing 1 to an error bit clears it, writing 0 leaves it unchanged, and writing 1 to status bit 3 clears the whole error register.
- R6: While `debug_halt` is high, a status write loads bits 1:0 with the written values, and an error-register write loads all eight error bits with the written byte.
- R7: While halted, a status write with bit 3 = 0 clears every error bit, and one with bit 3 = 1 sets every error bit.
- R8: Status bit 3 and `err_irq` both equal the OR of all error-register bits.
- R9: Bit-timing field bits 5:0 (address 3, reset value 0x20) accept a write only while control bit 4 is 1. Otherwise the write is ignored. Bits 7:6 read as 0.
- R10: The identifier register (address 4) stores a 6-bit ID in bits 5:0. Bits 7:6 are read-only parity: bit 6 = ID0^ID1^ID2^ID4 and bit 7 = NOT(ID1^ID3^ID4^ID5). The register reads back as `prot_id`, and its reset value is 0x80.
- R11: In normal LIN mode, the data register (address 6) reads and writes the buffer byte selected by the index register (address 5, bits 2:0). With auto-increment on, every data read or write advances the index, wrapping from 7 to 0. With auto-increment off, the index holds.
- R12: While halted in LIN mode, data accesses never move the index, even with auto-increment on.
- R13: In UART mode, a data write drives `uart_tx_byte` and a one-cycle `uart_tx_start` pulse on the next cycle. A data read returns the last byte captured on `uart_rx_valid`. The index does not change, index-register writes are ignored, and the buffer is not modified.
- R14: `freeze` equals `debug_halt` delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on data register only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| debug_halt | input | 1 | Debugger halt request |
| ev_rx_ok | input | 1 | Receive-complete event pulse |
| ev_tx_ok | input | 1 | Transmit-complete event pulse |
| ev_err | input | 8 | Per-bit error event pulses |
| fsm_state | input | 3 | Live protocol state from the engine |
| fsm_busy | input | 1 | Live busy indication from the engine |
| uart_rx_valid | input | 1 | UART received byte strobe |
| uart_rx_byte | input | 8 | UART received byte |
| uart_tx_byte | output | 8 | UART byte to transmit |
| uart_tx_start | output | 1 | One-cycle transmit request |
| freeze | output | 1 | Stops engine state machine and frame timeout counter |
| err_irq | output | 1 | Error interrupt flag |
| soft_reset | output | 1 | One-cycle controller reset pulse |
| ctrl_cfg | output | 7 | Control configuration bits |
| bit_time | output | 6 | Bit-timing field |
| prot_id | output | 8 | Protected identifier with parity |

## Verification
The bench targets the points where the two rule sets diverge. It checks that a halted status write with bit 3 clear wipes a populated error register, which a design reusing the write-one-clear path would leave intact. It checks that a halted data access leaves the index put, which a design with auto-increment wired unconditionally would move. It also drives the index across the 7-to-0 wrap and writes the bit-timing field with resynchronisation enabled, where a missing lock would let the value change. UART-mode accesses are followed by a LIN-mode read of the same buffer slot, which would catch a design that lets the transmit byte leak into the buffer or lets the index drift.

// File: rtl/lin_rf_pkg.sv
package lin_rf_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BT_W   = 6;
    localparam int unsigned ID_W   = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_STATUS = 3'd1,
        A_ERR    = 3'd2,
        A_TIMING = 3'd3,
        A_ID     = 3'd4,
        A_SEL    = 3'd5,
        A_DATA   = 3'd6
    } reg_addr_e;

    // Control bits 6:0 in register order
    typedef struct packed {
        logic       uart;
        logic       autoinc;
        logic       rsync_dis;
        logic [3:0] gp;
    } ctrl_t;

    localparam logic [BT_W-1:0] BT_RESET = 6'd32;

endpackage

// File: rtl/lin_rf_pid.sv
module lin_rf_pid
    import lin_rf_pkg::*;
(
    input  logic [ID_W-1:0]   id,
    output logic [BYTE_W-1:0] pid
);
    logic par_lo;
    logic par_hi;

    always_comb begin
        par_lo = id[0] ^ id[1] ^ id[2] ^ id[4];
        par_hi = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        pid    = {par_hi, par_lo, id};
    end
endmodule

// File: rtl/lin_rf_flags.sv
module lin_rf_flags
    import lin_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              st_wr,
    input  logic              err_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ev_rx,
    input  logic              ev_tx,
    input  logic [BYTE_W-1:0] ev_err,
    output logic              rx_ok,
    output logic              tx_ok,
    output logic [BYTE_W-1:0] err
);
    typedef struct packed {
        logic              rx;
        logic              tx;
        logic [BYTE_W-1:0] err;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!halted) begin
            // write-one-clear, then hardware set wins
            if (st_wr) begin
                if (wdata[0]) st_d.rx  = 1'b0;
                if (wdata[1]) st_d.tx  = 1'b0;
                if (wdata[3]) st_d.err = '0;
            end
            if (err_wr) st_d.err = st_d.err & ~wdata;
            st_d.rx  = st_d.rx | ev_rx;
            st_d.tx  = st_d.tx | ev_tx;
            st_d.err = st_d.err | ev_err;
        end else begin
            // events first, direct debug writes override
            st_d.rx  = st_d.rx | ev_rx;
            st_d.tx  = st_d.tx | ev_tx;
            st_d.err = st_d.err | ev_err;
            if (st_wr) begin
                st_d.rx  = wdata[0];
                st_d.tx  = wdata[1];
                st_d.err = {BYTE_W{wdata[3]}};
            end
            if (err_wr) st_d.err = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_ok = st_q.rx;
    assign tx_ok = st_q.tx;
    assign err   = st_q.err;
endmodule

// File: rtl/lin_rf_buffer.sv
module lin_rf_buffer
    import lin_rf_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IW   = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              uart,
    input  logic              autoinc,
    input  logic              sel_wr,
    input  logic [IW-1:0]     sel_val,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [IW-1:0]     idx,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_start
);
    localparam logic [IW-1:0] IDX_LAST = IW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [IW-1:0]                idx;
        logic [BYTE_W-1:0]            rxb;
        logic [BYTE_W-1:0]            txb;
        logic                         txs;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        b_d.txs = 1'b0;
        if (rx_valid) b_d.rxb = rx_byte;
        if (uart) begin
            if (data_wr) begin
                b_d.txb = wdata;
                b_d.txs = 1'b1;
            end
        end else begin
            if (data_wr) b_d.mem[b_q.idx] = wdata;
            if (sel_wr) begin
                b_d.idx = sel_val;
            end else if (!halted && autoinc && (data_wr || data_rd)) begin
                b_d.idx = (b_q.idx == IDX_LAST) ? '0 : b_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign idx      = b_q.idx;
    assign rd_byte  = uart ? b_q.rxb : b_q.mem[b_q.idx];
    assign tx_byte  = b_q.txb;
    assign tx_start = b_q.txs;
endmodule

// File: rtl/lin_regfile.sv
module lin_regfile
    import lin_rf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic               debug_halt,
    input  logic               ev_rx_ok,
    input  logic               ev_tx_ok,
    input  logic [BYTE_W-1:0]  ev_err,
    input  logic [2:0]         fsm_state,
    input  logic               fsm_busy,
    input  logic               uart_rx_valid,
    input  logic [BYTE_W-1:0]  uart_rx_byte,
    output logic [BYTE_W-1:0]  uart_tx_byte,
    output logic               uart_tx_start,
    output logic               freeze,
    output logic               err_irq,
    output logic               soft_reset,
    output logic [6:0]         ctrl_cfg,
    output logic [BT_W-1:0]    bit_time,
    output logic [BYTE_W-1:0]  prot_id
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    typedef struct packed {
        ctrl_t           ctrl;
        logic            srst;
        logic [BT_W-1:0] bt;
        logic [ID_W-1:0] id;
        logic            frz;
    } top_t;

    top_t q, d;

    logic              wr_ctrl, wr_stat, wr_err, wr_bt, wr_id, wr_sel, wr_dat, rd_dat;
    logic              rx_ok, tx_ok;
    logic [BYTE_W-1:0] err_bits;
    logic [IDX_W-1:0]  cur_idx;
    logic [BYTE_W-1:0] buf_byte;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_stat = bus_wr && (bus_addr == A_STATUS);
        wr_err  = bus_wr && (bus_addr == A_ERR);
        wr_bt   = bus_wr && (bus_addr == A_TIMING);
        wr_id   = bus_wr && (bus_addr == A_ID);
        wr_sel  = bus_wr && (bus_addr == A_SEL);
        wr_dat  = bus_wr && (bus_addr == A_DATA);
        rd_dat  = bus_rd && (bus_addr == A_DATA);
    end

    always_comb begin
        d      = q;
        d.srst = 1'b0;
        d.frz  = debug_halt;
        if (wr_ctrl) begin
            d.ctrl = bus_wdata[6:0];
            d.srst = bus_wdata[7];
        end
        if (wr_bt && q.ctrl.rsync_dis) d.bt = bus_wdata[BT_W-1:0];
        if (wr_id) d.id = bus_wdata[ID_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.bt <= BT_RESET;
        end else begin
            q <= d;
        end
    end

    lin_rf_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .halted (debug_halt),
        .st_wr  (wr_stat),
        .err_wr (wr_err),
        .wdata  (bus_wdata),
        .ev_rx  (ev_rx_ok),
        .ev_tx  (ev_tx_ok),
        .ev_err (ev_err),
        .rx_ok  (rx_ok),
        .tx_ok  (tx_ok),
        .err    (err_bits)
    );

    lin_rf_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted   (debug_halt),
        .uart     (q.ctrl.uart),
        .autoinc  (q.ctrl.autoinc),
        .sel_wr   (wr_sel),
        .sel_val  (bus_wdata[IDX_W-1:0]),
        .data_wr  (wr_dat),
        .data_rd  (rd_dat),
        .wdata    (bus_wdata),
        .rx_valid (uart_rx_valid),
        .rx_byte  (uart_rx_byte),
        .idx      (cur_idx),
        .rd_byte  (buf_byte),
        .tx_byte  (uart_tx_byte),
        .tx_start (uart_tx_start)
    );

    lin_rf_pid u_pid (
        .id  (q.id),
        .pid (prot_id)
    );

    always_comb begin
        err_irq = |err_bits;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = {1'b0, q.ctrl};
            A_STATUS: bus_rdata = {fsm_state, fsm_busy, err_irq, 1'b0, tx_ok, rx_ok};
            A_ERR:    bus_rdata = err_bits;
            A_TIMING: bus_rdata = {{(BYTE_W-BT_W){1'b0}}, q.bt};
            A_ID:     bus_rdata = prot_id;
            A_SEL:    bus_rdata = {{(BYTE_W-IDX_W){1'b0}}, cur_idx};
            A_DATA:   bus_rdata = buf_byte;
            default:  bus_rdata = '0;
        endcase
    end

    assign freeze     = q.frz;
    assign soft_reset = q.srst;
    assign ctrl_cfg   = q.ctrl;
    assign bit_time   = q.bt;
endmodule

// File: rtl/lin_regfile_chk.sv
module lin_regfile_chk #(
    parameter int unsigned IW = 3
)(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [2:0]    bus_addr,
    input logic          srst_bit,
    input logic          debug_halt,
    input logic [7:0]    ev_err,
    input logic          freeze,
    input logic          err_irq,
    input logic          soft_reset,
    input logic [6:0]    ctrl_cfg,
    input logic [5:0]    bit_time,
    input logic [IW-1:0] idx,
    input logic          uart_tx_start
);
    logic srst_req, dat_acc, flag_wr;

    always_comb begin
        srst_req = bus_wr && (bus_addr == 3'd0) && srst_bit;
        dat_acc  = (bus_wr || bus_rd) && (bus_addr == 3'd6);
        flag_wr  = bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd2);
    end

    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> soft_reset); // R1
    AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset && !srst_req |=> !soft_reset); // R1
    AST_FREEZE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        debug_halt |=> freeze); // R14
    AST_FREEZE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_halt |=> !freeze); // R14
    AST_ERR_EVENT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_err) && !flag_wr |=> err_irq); // R8
    AST_TIMING_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == 3'd3) && !ctrl_cfg[4] |=> $stable(bit_time)); // R9
    AST_AUTOINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dat_acc && !debug_halt && !ctrl_cfg[6] && ctrl_cfg[5]
        |=> idx == IW'($past(idx) + 1'b1)); // R11
    AST_HALT_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dat_acc && debug_halt |=> $stable(idx)); // R12
    AST_UART_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dat_acc && ctrl_cfg[6] |=> $stable(idx)); // R13
    AST_UART_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == 3'd6) && ctrl_cfg[6] |=> uart_tx_start); // R13
endmodule

bind lin_regfile lin_regfile_chk #(.IW(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .srst_bit      (bus_wdata[7]),
    .debug_halt    (debug_halt),
    .ev_err        (ev_err),
    .freeze        (freeze),
    .err_irq       (err_irq),
    .soft_reset    (soft_reset),
    .ctrl_cfg      (ctrl_cfg),
    .bit_time      (bit_time),
    .idx           (cur_idx),
    .uart_tx_start (uart_tx_start)
);

// File: tb/lin_regfile_bench.sv
`timescale 1ns/1ps
module lin_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       debug_halt = 1'b0;
    logic       ev_rx_ok = 1'b0, ev_tx_ok = 1'b0;
    logic [7:0] ev_err = '0;
    logic [2:0] fsm_state = '0;
    logic       fsm_busy = 1'b0;
    logic       uart_rx_valid = 1'b0;
    logic [7:0] uart_rx_byte = '0;
    logic [7:0] uart_tx_byte;
    logic       uart_tx_start, freeze, err_irq, soft_reset;
    logic [6:0] ctrl_cfg;
    logic [5:0] bit_time;
    logic [7:0] prot_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lin_regfile u_lin_regfile (.*);

    // {value written to ID register, expected read-back} for R10
    localparam logic [15:0] PID_VEC [10] = '{
        16'h00_80, 16'hFF_BF, 16'h01_C1, 16'h02_42, 16'h08_08,
        16'h10_50, 16'h20_20, 16'h3C_3C, 16'hD5_55, 16'h40_80
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(string req, logic [2:0] a, logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        rdchk("R2 ctrl reset", 3'd0, 8'h00);
        rdchk("R4 status reset", 3'd1, 8'h00);
        rdchk("R5 err reset", 3'd2, 8'h00);
        rdchk("R9 timing reset", 3'd3, 8'h20);
        rdchk("R10 id reset", 3'd4, 8'h80);
        rdchk("R11 sel reset", 3'd5, 8'h00);
        chk("R14 freeze reset", {7'd0, freeze}, 8'h00);

        // R10 vector table
        for (int i = 0; i < 10; i++) begin
            wr(3'd4, PID_VEC[i][15:8]);
            rdchk("R10 id parity", 3'd4, PID_VEC[i][7:0]);
            chk("R10 prot_id port", prot_id, PID_VEC[i][7:0]);
        end

        // R2 / R1
        wr(3'd0, 8'h0F);
        rdchk("R2 ctrl rw", 3'd0, 8'h0F);
        chk("R2 ctrl_cfg", {1'b0, ctrl_cfg}, 8'h0F);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h8F;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R1 soft reset pulse", {7'd0, soft_reset}, 8'h01);
        @(negedge clk);
        chk("R1 soft reset self clear", {7'd0, soft_reset}, 8'h00);
        rdchk("R1 bit7 reads zero", 3'd0, 8'h0F);

        // R3
        fsm_state = 3'd5; fsm_busy = 1'b1;
        rdchk("R3 state/busy view", 3'd1, 8'hB0);
        wr(3'd1, 8'hFF);
        rdchk("R3 state/busy read-only", 3'd1, 8'hB0);
        fsm_state = 3'd0; fsm_busy = 1'b0;

        // R4
        @(negedge clk); ev_rx_ok = 1'b1; @(negedge clk); ev_rx_ok = 1'b0;
        rdchk("R4 rx set", 3'd1, 8'h01);
        wr(3'd1, 8'h02);
        rdchk("R4 write1 other bit keeps rx", 3'd1, 8'h01);
        wr(3'd1, 8'h00);
        rdchk("R4 write0 keeps rx", 3'd1, 8'h01);
        wr(3'd1, 8'h01);
        rdchk("R4 rx clear", 3'd1, 8'h00);
        @(negedge clk); ev_tx_ok = 1'b1; @(negedge clk); ev_tx_ok = 1'b0;
        rdchk("R4 tx set", 3'd1, 8'h02);
        wr(3'd1, 8'h02);
        rdchk("R4 tx clear", 3'd1, 8'h00);

        // R5 / R8
        @(negedge clk); ev_err = 8'h05; @(negedge clk); ev_err = 8'h00;
        rdchk("R5 err set", 3'd2, 8'h05);
        chk("R8 err_irq", {7'd0, err_irq}, 8'h01);
        rdchk("R8 summary bit", 3'd1, 8'h08);
        wr(3'd2, 8'h01);
        rdchk("R5 err w1c", 3'd2, 8'h04);
        wr(3'd2, 8'h00);
        rdchk("R5 err write0 no effect", 3'd2, 8'h04);
        wr(3'd1, 8'h08);
        rdchk("R5 summary clears all", 3'd2, 8'h00);
        chk("R8 err_irq low", {7'd0, err_irq}, 8'h00);

        // R9
        wr(3'd3, 8'h11);
        rdchk("R9 locked write ignored", 3'd3, 8'h20);
        wr(3'd0, 8'h1F);
        wr(3'd3, 8'h11);
        rdchk("R9 unlocked write", 3'd3, 8'h11);
        wr(3'd3, 8'hFF);
        rdchk("R9 upper bits zero", 3'd3, 8'h3F);

        // R11
        wr(3'd0, 8'h20);
        wr(3'd5, 8'h06);
        wr(3'd6, 8'hA0);
        wr(3'd6, 8'hA1);
        wr(3'd6, 8'hA2);
        rdchk("R11 index wraps", 3'd5, 8'h01);
        wr(3'd5, 8'h06);
        rdchk("R11 read slot6", 3'd6, 8'hA0);
        rdchk("R11 read slot7", 3'd6, 8'hA1);
        rdchk("R11 read slot0", 3'd6, 8'hA2);
        rdchk("R11 index after reads", 3'd5, 8'h01);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h03);
        wr(3'd6, 8'h33);
        rdchk("R11 no autoinc holds", 3'd5, 8'h03);
        rdchk("R11 read back", 3'd6, 8'h33);

        // R14 / R12
        @(negedge clk); debug_halt = 1'b1;
        @(negedge clk);
        chk("R14 freeze rises", {7'd0, freeze}, 8'h01);
        wr(3'd0, 8'h20);
        rdchk("R2 ctrl rw halted", 3'd0, 8'h20);
        wr(3'd5, 8'h02);
        wr(3'd6, 8'h5A);
        rdchk("R12 halted write no inc", 3'd5, 8'h02);
        wr(3'd5, 8'h06);
        rdchk("R12 halted read slot6", 3'd6, 8'hA0);
        rdchk("R12 halted read no inc", 3'd5, 8'h06);

        // R6 / R7
        wr(3'd1, 8'h03);
        rdchk("R6 direct set", 3'd1, 8'h03);
        wr(3'd1, 8'h00);
        rdchk("R6 direct clear", 3'd1, 8'h00);
        wr(3'd1, 8'h08);
        rdchk("R7 summary sets all", 3'd2, 8'hFF);
        chk("R8 err_irq halted", {7'd0, err_irq}, 8'h01);
        wr(3'd2, 8'h40);
        rdchk("R6 err direct write", 3'd2, 8'h40);
        wr(3'd1, 8'h01);
        rdchk("R7 summary zero clears all", 3'd2, 8'h00);
        rdchk("R6 rx direct with err clear", 3'd1, 8'h01);
        wr(3'd1, 8'h00);

        // R1 while halted
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'hA0;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R1 soft reset halted", {7'd0, soft_reset}, 8'h01);

        @(negedge clk); debug_halt = 1'b0;
        @(negedge clk);
        chk("R14 freeze falls", {7'd0, freeze}, 8'h00);

        // R13
        wr(3'd0, 8'h60);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h3C;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R13 tx start", {7'd0, uart_tx_start}, 8'h01);
        chk("R13 tx byte", uart_tx_byte, 8'h3C);
        @(negedge clk);
        chk("R13 tx start one cycle", {7'd0, uart_tx_start}, 8'h00);
        rdchk("R13 index unchanged", 3'd5, 8'h06);
        @(negedge clk); uart_rx_valid = 1'b1; uart_rx_byte = 8'h99;
        @(negedge clk); uart_rx_valid = 1'b0;
        rdchk("R13 rx byte", 3'd6, 8'h99);
        wr(3'd5, 8'h01);
        rdchk("R13 sel write ignored", 3'd5, 8'h06);
        wr(3'd0, 8'h00);
        rdchk("R13 buffer untouched", 3'd6, 8'hA0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule